// File: doc/BRIEF.md
# Periodic Burst Attack Detector

This block watches the traffic headed for one output port and decides whether that traffic looks like a pulsed denial-of-service pattern. Such a pattern consists of short, intense bursts that overflow the port queue, repeated at about the minimum TCP retransmission timeout. Every packet headed for the port is reported as a byte count. A tick input marks the end of each measurement bin, nominally 1 ms. A bin is busy when its bytes exceed the port's capacity for one bin. After a programmable number of bins (the window, typically 3000), the block applies three tests to the window. The first test asks whether the busy bins carried more than 90% of the bytes. The second asks whether the busy bins took up less than 10% of the bins. The third asks whether successive busy runs started at a steady spacing close to a target period. The result is registered as the attack flag.

While the flag is set, a token-bucket shaper governs a request/grant path for the suspect traffic. The bucket gains a programmed number of bytes of credit on every tick and is capped at a programmed depth. A packet whose length exceeds the current credit is held, not dropped, until enough credit has built up. While the flag is clear, every request is granted at once.

Window control is a three-state machine. The states are ST_QUIET (the last bin was idle), ST_BUSY (inside a busy run) and ST_EVAL (a one-cycle verdict state).
- A busy bin moves ST_QUIET to ST_BUSY; this move is the start of a run.
- An idle bin moves ST_BUSY back to ST_QUIET.
- The bin that completes the window moves either state to ST_EVAL.
- ST_EVAL always returns to ST_QUIET.

Ticks must be at least two clock cycles apart.

Top module: `lrbd_top`

## Requirements
- R1: Bytes reported during one bin are summed, including a packet reported in the tick cycle. A bin is busy only when that sum is strictly greater than `cfg_speed`; a sum equal to `cfg_speed` is idle.
- R2: The volume test passes only when 10 × (busy-bin bytes) > 9 × (all bytes in the window); a window with no bytes fails it.
- R3: The time test passes only when 10 × (busy bins) < `cfg_win_bins`.
- R4: A run start is a busy bin that follows an idle bin or opens the window. The gap is the bin-index distance between successive run starts. The period test passes only when at least two gaps were seen in the window and every gap g satisfies |g − `cfg_period`| ≤ `cfg_tol`.
- R5: The tick that closes bin number `cfg_win_bins` ends the window. `win_done` is a one-cycle pulse on the second rising edge after that tick's edge. On the same edge, `attack` takes the AND of the three tests.
- R6: `attack` keeps its value between window ends. All window statistics and the run/gap history restart at each window boundary.
- R7: `shape_en` equals `attack`. While it is 0, `fwd_grant` equals `fwd_req` whatever the credit.
- R8: On each tick the credit increases by `cfg_rate`, saturating at `cfg_depth`. Credit changes only on a tick or a granted shaped packet.
- R9: While `shape_en` is 1, `fwd_grant` is 1 exactly when `fwd_req` is 1 and credit ≥ `fwd_len`. A grant spends `fwd_len` credit; a refused request spends nothing and stays pending.
- R10: Reset clears `attack`, `shape_en`, `win_done`, the credit and all window state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | End-of-bin strobe (one cycle) |
| pkt_valid | input | 1 | A packet toward the port is reported this cycle |
| pkt_bytes | input | LEN_W | Length of the reported packet in bytes |
| cfg_speed | input | BIN_W | Port capacity in bytes per bin |
| cfg_win_bins | input | CNT_W | Bins per evaluation window |
| cfg_period | input | CNT_W | Target run-start spacing in bins |
| cfg_tol | input | CNT_W | Allowed deviation from the target spacing in bins |
| cfg_rate | input | TOK_W | Credit bytes added per tick |
| cfg_depth | input | TOK_W | Maximum credit in bytes |
| fwd_req | input | 1 | Suspect packet asks to be forwarded |
| fwd_len | input | LEN_W | Length of the requesting packet |
| fwd_grant | output | 1 | Packet may go this cycle |
| attack | output | 1 | Verdict of the last completed window |
| shape_en | output | 1 | Shaper active |
| win_done | output | 1 | Window verdict strobe |

## Verification
A corrupted bin sum, busy decision or gap counter stays hidden until the window closes. It then shows as a wrong `attack` value two cycles after the last tick, so the stimulus is grouped into whole windows. Each window pattern is chosen so that exactly one test sits at or just past its boundary. A state machine that leaves ST_EVAL late or skips it shows at once as a missing or doubled `win_done` pulse, or as `attack` changing in mid-window. Credit errors in the shaper show within one cycle on `fwd_grant`, so the bucket is driven to exact equality, one byte short, and its cap.

// File: rtl/lrbd_pkg.sv
package lrbd_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_BUSY  = 2'd1,
        ST_EVAL  = 2'd2
    } win_state_e;

    // Percent tests are done as integer ratios against this scale.
    localparam int PCT_SCALE = 10;

endpackage

// File: rtl/lrbd_binner.sv
module lrbd_binner #(
    parameter int LEN_W = 16,
    parameter int BIN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_bytes,
    input  logic [BIN_W-1:0] cfg_speed,
    output logic             bin_valid,
    output logic [BIN_W-1:0] bin_bytes,
    output logic             bin_busy
);

    logic [BIN_W-1:0] acc_q;
    logic [BIN_W-1:0] acc_sum;

    always_comb begin
        acc_sum = acc_q + (pkt_valid ? BIN_W'(pkt_bytes) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            bin_valid <= 1'b0;
            bin_bytes <= '0;
            bin_busy  <= 1'b0;
        end else begin
            bin_valid <= tick;
            if (tick) begin
                bin_bytes <= acc_sum;
                bin_busy  <= (acc_sum > cfg_speed);
                acc_q     <= '0;
            end else begin
                acc_q <= acc_sum;
            end
        end
    end

endmodule

// File: rtl/lrbd_window.sv
module lrbd_window
    import lrbd_pkg::*;
#(
    parameter int BIN_W = 24,
    parameter int ACC_W = 40,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bin_valid,
    input  logic [BIN_W-1:0] bin_bytes,
    input  logic             bin_busy,
    input  logic [CNT_W-1:0] cfg_win_bins,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_tol,
    output logic             attack,
    output logic             win_done
);

    localparam int VW = ACC_W + 4;
    localparam int TW = CNT_W + 4;

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] bin_cnt_q;
    logic [ACC_W-1:0] tot_bytes_q;
    logic [ACC_W-1:0] busy_bytes_q;
    logic [CNT_W-1:0] busy_bins_q;
    logic [CNT_W-1:0] since_q;
    logic             have_start_q;
    logic [1:0]       gaps_q;
    logic             gap_bad_q;

    logic             last_bin;
    logic             run_start;
    logic [CNT_W-1:0] gap_diff;
    logic             gap_in_tol;
    logic             vol_ok, time_ok, per_ok, verdict;

    always_comb begin
        last_bin   = (bin_cnt_q + CNT_W'(1)) == cfg_win_bins;
        run_start  = bin_valid && bin_busy && (state_q == ST_QUIET);
        gap_diff   = (since_q >= cfg_period) ? (since_q - cfg_period)
                                             : (cfg_period - since_q);
        gap_in_tol = (gap_diff <= cfg_tol);

        vol_ok  = (VW'(busy_bytes_q) * VW'(PCT_SCALE)) >
                  (VW'(tot_bytes_q) * VW'(PCT_SCALE - 1));
        time_ok = (TW'(busy_bins_q) * TW'(PCT_SCALE)) < TW'(cfg_win_bins);
        per_ok  = (gaps_q == 2'd2) && !gap_bad_q;
        verdict = vol_ok && time_ok && per_ok;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (bin_valid) state_d = last_bin ? ST_EVAL :
                                               (bin_busy ? ST_BUSY : ST_QUIET);
            ST_BUSY:  if (bin_valid) state_d = last_bin ? ST_EVAL :
                                               (bin_busy ? ST_BUSY : ST_QUIET);
            ST_EVAL:  state_d = ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Window statistics
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_cnt_q    <= '0;
            tot_bytes_q  <= '0;
            busy_bytes_q <= '0;
            busy_bins_q  <= '0;
            since_q      <= '0;
            have_start_q <= 1'b0;
            gaps_q       <= '0;
            gap_bad_q    <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            bin_cnt_q    <= '0;
            tot_bytes_q  <= '0;
            busy_bytes_q <= '0;
            busy_bins_q  <= '0;
            since_q      <= '0;
            have_start_q <= 1'b0;
            gaps_q       <= '0;
            gap_bad_q    <= 1'b0;
        end else if (bin_valid) begin
            bin_cnt_q   <= bin_cnt_q + CNT_W'(1);
            tot_bytes_q <= tot_bytes_q + ACC_W'(bin_bytes);
            if (bin_busy) begin
                busy_bytes_q <= busy_bytes_q + ACC_W'(bin_bytes);
                busy_bins_q  <= busy_bins_q + CNT_W'(1);
            end
            if (run_start) begin
                since_q      <= CNT_W'(1);
                have_start_q <= 1'b1;
                if (have_start_q) begin
                    if (gaps_q != 2'd2) gaps_q <= gaps_q + 2'd1;
                    if (!gap_in_tol)    gap_bad_q <= 1'b1;
                end
            end else if (have_start_q && (since_q != '1)) begin
                since_q <= since_q + CNT_W'(1);
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attack   <= 1'b0;
            win_done <= 1'b0;
        end else begin
            win_done <= (state_q == ST_EVAL);
            if (state_q == ST_EVAL) attack <= verdict;
        end
    end

endmodule

// File: rtl/lrbd_shaper.sv
module lrbd_shaper #(
    parameter int LEN_W = 16,
    parameter int TOK_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [TOK_W-1:0] cfg_rate,
    input  logic [TOK_W-1:0] cfg_depth,
    input  logic             req,
    input  logic [LEN_W-1:0] len,
    output logic             grant
);

    localparam int RW = TOK_W + 1;

    logic [TOK_W-1:0] tok_q;
    logic [TOK_W-1:0] spent, after, tok_d;
    logic [RW-1:0]    refill;
    logic             fits;

    always_comb begin
        fits   = RW'(tok_q) >= RW'(len);
        grant  = req && (!en || fits);
        spent  = (grant && en) ? TOK_W'(len) : '0;
        after  = tok_q - spent;
        refill = RW'(after) + RW'(cfg_rate);
        if (tick) tok_d = (refill > RW'(cfg_depth)) ? cfg_depth : refill[TOK_W-1:0];
        else      tok_d = after;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok_q <= '0;
        else        tok_q <= tok_d;
    end

endmodule

// File: rtl/lrbd_top.sv
module lrbd_top #(
    parameter int LEN_W = 16,
    parameter int BIN_W = 24,
    parameter int ACC_W = 40,
    parameter int CNT_W = 16,
    parameter int TOK_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_bytes,
    input  logic [BIN_W-1:0] cfg_speed,
    input  logic [CNT_W-1:0] cfg_win_bins,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_tol,
    input  logic [TOK_W-1:0] cfg_rate,
    input  logic [TOK_W-1:0] cfg_depth,
    input  logic             fwd_req,
    input  logic [LEN_W-1:0] fwd_len,
    output logic             fwd_grant,
    output logic             attack,
    output logic             shape_en,
    output logic             win_done
);

    logic             bin_valid;
    logic [BIN_W-1:0] bin_bytes;
    logic             bin_busy;

    lrbd_binner #(.LEN_W(LEN_W), .BIN_W(BIN_W)) u_binner (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pkt_valid (pkt_valid),
        .pkt_bytes (pkt_bytes),
        .cfg_speed (cfg_speed),
        .bin_valid (bin_valid),
        .bin_bytes (bin_bytes),
        .bin_busy  (bin_busy)
    );

    lrbd_window #(.BIN_W(BIN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .bin_valid    (bin_valid),
        .bin_bytes    (bin_bytes),
        .bin_busy     (bin_busy),
        .cfg_win_bins (cfg_win_bins),
        .cfg_period   (cfg_period),
        .cfg_tol      (cfg_tol),
        .attack       (attack),
        .win_done     (win_done)
    );

    assign shape_en = attack;

    lrbd_shaper #(.LEN_W(LEN_W), .TOK_W(TOK_W)) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (shape_en),
        .tick      (tick),
        .cfg_rate  (cfg_rate),
        .cfg_depth (cfg_depth),
        .req       (fwd_req),
        .len       (fwd_len),
        .grant     (fwd_grant)
    );

endmodule

// File: rtl/lrbd_chk.sv
module lrbd_win_chk (
    input logic clk,
    input logic rst_n,
    input logic attack,
    input logic win_done
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    // R6
    attack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> $stable(attack));

endmodule

module lrbd_shp_chk #(
    parameter int LEN_W = 16,
    parameter int TOK_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             tick,
    input logic             req,
    input logic [LEN_W-1:0] len,
    input logic             grant,
    input logic [TOK_W-1:0] tok_q
);

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && req) |-> grant);

    // R9
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req);

    // R8
    credit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_q > $past(tok_q)) |-> $past(tick));

    // R9
    credit_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && grant && !tick) |=> (tok_q == $past(tok_q) - TOK_W'($past(len))));

endmodule

bind lrbd_window lrbd_win_chk win_chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .attack   (attack),
    .win_done (win_done)
);

bind lrbd_shaper lrbd_shp_chk #(.LEN_W(LEN_W), .TOK_W(TOK_W)) shp_chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick),
    .req   (req),
    .len   (len),
    .grant (grant),
    .tok_q (tok_q)
);

// File: tb/lrbd_top_tb_top.sv
module lrbd_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        pkt_valid;
    logic [15:0] pkt_bytes;
    logic [23:0] cfg_speed;
    logic [15:0] cfg_win_bins, cfg_period, cfg_tol;
    logic [23:0] cfg_rate, cfg_depth;
    logic        fwd_req;
    logic [15:0] fwd_len;
    logic        fwd_grant, attack, shape_en, win_done;

    always #2 clk = ~clk;

    lrbd_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pkt_valid(pkt_valid),
        .pkt_bytes(pkt_bytes), .cfg_speed(cfg_speed), .cfg_win_bins(cfg_win_bins),
        .cfg_period(cfg_period), .cfg_tol(cfg_tol), .cfg_rate(cfg_rate),
        .cfg_depth(cfg_depth), .fwd_req(fwd_req), .fwd_len(fwd_len),
        .fwd_grant(fwd_grant), .attack(attack), .shape_en(shape_en),
        .win_done(win_done)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // One bin: two packets, a tick, then wait to the second edge after the tick.
    task automatic run_bin(input int bytes);
        @(negedge clk);
        pkt_valid = (bytes / 2) > 0;
        pkt_bytes = 16'(bytes / 2);
        @(negedge clk);
        pkt_valid = (bytes - bytes / 2) > 0;
        pkt_bytes = 16'(bytes - bytes / 2);
        @(negedge clk);
        pkt_valid = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    typedef struct packed {
        logic [39:0] mask;
        logic [15:0] hi;
        logic [15:0] lo;
        logic        exp;
    } vec_t;

    // Window 40 bins, speed 100 B/bin, target period 12, tolerance 1.
    localparam vec_t VEC [9] = '{
        '{40'h00_0400_4004, 16'd400, 16'd2,  1'b1},
        '{40'h00_0400_4004, 16'd400, 16'd20, 1'b0},
        '{40'h00_0400_400C, 16'd400, 16'd2,  1'b0},
        '{40'h00_1000_4004, 16'd400, 16'd2,  1'b0},
        '{40'h00_0400_2004, 16'd400, 16'd2,  1'b1},
        '{40'h00_0000_4004, 16'd400, 16'd2,  1'b0},
        '{40'h00_0000_0000, 16'd0,   16'd0,  1'b0},
        '{40'h00_0400_4004, 16'd100, 16'd0,  1'b0},
        '{40'h00_0400_4004, 16'd101, 16'd0,  1'b1}
    };

    string tags [9] = '{
        "R5 all three tests met",
        "R2 volume share too low",
        "R3 busy time share reaches 10%",
        "R4 gap outside tolerance",
        "R4 gaps at tolerance edge",
        "R4 only one gap",
        "R2 empty window",
        "R1 bin equal to speed is idle",
        "R1 split packets above speed"
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R5 watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic prev;
        rst_n = 1'b0; tick = 1'b0; pkt_valid = 1'b0; pkt_bytes = '0;
        cfg_speed = 24'd100; cfg_win_bins = 16'd40; cfg_period = 16'd12;
        cfg_tol = 16'd1; cfg_rate = 24'd50; cfg_depth = 24'd200;
        fwd_req = 1'b0; fwd_len = '0;
        repeat (4) @(negedge clk);
        #1;
        chk("R10 attack after reset", attack, 0);
        chk("R10 shape_en after reset", shape_en, 0);
        chk("R10 win_done after reset", win_done, 0);
        chk("R9 no grant without request", fwd_grant, 0);
        rst_n = 1'b1;

        prev = 1'b0;
        for (int w = 0; w < 9; w++) begin
            for (int b = 0; b < 40; b++) begin
                run_bin(VEC[w].mask[b] ? int'(VEC[w].hi) : int'(VEC[w].lo));
                if (b == 20) begin
                    chk("R6 flag held mid-window", attack, prev);
                    chk("R5 no strobe mid-window", win_done, 0);
                end
                if (b == 39) begin
                    chk("R5 strobe at window end", win_done, 1);
                    chk(tags[w], attack, VEC[w].exp);
                    chk("R7 shape_en follows flag", shape_en, VEC[w].exp);
                end
            end
            prev = VEC[w].exp;
        end

        // Shaper active, bucket full at 200.
        @(negedge clk);
        fwd_req = 1'b1; fwd_len = 16'd150; #1;
        chk("R9 grant with enough credit", fwd_grant, 1);
        @(negedge clk); #1;
        chk("R9 held when credit short", fwd_grant, 0);
        @(negedge clk);
        fwd_len = 16'd50; #1;
        chk("R9 refused request spent nothing", fwd_grant, 1);
        @(negedge clk);
        fwd_req = 1'b0;
        tick_once();
        fwd_req = 1'b1; fwd_len = 16'd51; #1;
        chk("R8 one tick adds rate only", fwd_grant, 0);
        @(negedge clk);
        fwd_len = 16'd50; #1;
        chk("R8 one tick adds rate", fwd_grant, 1);
        @(negedge clk);
        fwd_req = 1'b0;
        repeat (6) tick_once();
        fwd_req = 1'b1; fwd_len = 16'd201; #1;
        chk("R8 credit capped at depth", fwd_grant, 0);
        @(negedge clk);
        fwd_len = 16'd200; #1;
        chk("R8 credit reaches depth", fwd_grant, 1);
        @(negedge clk);
        fwd_req = 1'b0;

        rst_n = 1'b0;
        @(negedge clk); #1;
        chk("R10 attack cleared by reset", attack, 0);
        chk("R10 shape_en cleared by reset", shape_en, 0);
        chk("R10 win_done cleared by reset", win_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        fwd_req = 1'b1; fwd_len = 16'd1000; #1;
        chk("R7 pass-through when shaper off", fwd_grant, 1);
        @(negedge clk);
        fwd_req = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule